// File: doc/BRIEF.md
# PLL Configuration Register Bank

This block is the software-visible front end of a clock-multiplying PLL. A byte-wide bus with an address, a write strobe and combinational read data lets software switch the loop on, choose between automatic and manual loop-bandwidth handling, watch the lock state, steer the acquisition/tracking phase by hand, and program the 12-bit feedback multiplier. The PLL core feeds back its lock flag and its own acquisition/tracking state, and it receives the enable, the bandwidth mode, the manual acquisition command and the effective multiplier.

Some bits change meaning with the bandwidth mode. In automatic mode the lock bit and the acquisition bit show the live core state, and writes to the acquisition bit are ignored. In manual mode the lock bit reads 0, and the acquisition bit becomes a writable command. The last value written by hand is kept in a shadow register while automatic mode runs, and it comes back when manual mode resumes. The multiplier is locked against writes while the PLL is enabled, and a programmed zero is presented to the core as one.

Top module: `pll_regbank`

## Requirements
- R1: After reset, the enable bit, the automatic-bandwidth bit and the acquisition bit are 0, and the multiplier is 0x040. Offset 0x08 reads 0x00, offset 0x09 reads 0x40, and `mult_eff` is 0x040.
- R2: The register at offset 0x06 holds the PLL enable in bit 5. The other bits read 0. The enable bit drives `pll_enable`.
- R3: The register at offset 0x07 holds the automatic-bandwidth bit in bit 7 and the lock bit in bit 6. In automatic mode bit 6 reads the live `core_locked` input. In manual mode it reads 0.
- R4: Writing 1 to the lock bit has no effect. The bit still reads 0 in manual mode and still follows `core_locked` in automatic mode.
- R5: In automatic mode, bit 5 of offset 0x07 reads `core_tracking` (1 = tracking, 0 = acquisition), and writes to that bit are ignored.
- R6: In manual mode, bit 5 of offset 0x07 is read/write, and its value drives `acq_track_cmd`.
- R7: A write is handled by the mode that is in force when it arrives. The write that leaves automatic mode therefore does not change the shadow. After it, bit 5 reads the last value written in manual mode.
- R8: Multiplier bits 11:8 sit in bits 3:0 of offset 0x08, whose upper nibble reads 0. Bits 7:0 sit at offset 0x09.
- R9: Writes to offset 0x08 or 0x09 are ignored while `pll_enable` is 1.
- R10: A programmed multiplier of 0x000 gives `mult_eff` = 0x001. The registers still read back 0x00.
- R11: Unmapped offsets read 0x00, and writes to them change no register.
- R12: A write becomes visible on the clock edge after the strobe. During the strobe cycle the old value is still read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| core_locked | input | 1 | Lock status from the PLL core |
| core_tracking | input | 1 | Acquisition (0) / tracking (1) state of the core in automatic mode |
| pll_enable | output | 1 | PLL enable to the core |
| bw_auto | output | 1 | 1 selects automatic bandwidth control |
| acq_track_cmd | output | 1 | Manual acquisition (0) / tracking (1) command |
| mult_eff | output | 12 | Effective feedback multiplier, never zero |

## Verification
The bandwidth register is exercised in four mode sequences:
- manual writes,
- entry into automatic mode,
- automatic-mode writes while the core inputs toggle,
- the return to manual.

Together these separate a correct shadow from one that tracks every write or drops the saved value.

The multiplier is written with a mixed nibble pattern, with all-ones in the upper high-byte nibble, and with zero and one. These cases expose swapped nibbles, missing masking and a missing zero clamp. The same writes are repeated with the PLL enabled, to show that the write lock holds. Offset 0x07 is then read in each mode with `core_locked` at both levels, to separate a live lock readout from a stored one.

// File: rtl/pllrb_pkg.sv
package pllrb_pkg;
   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned EN_BIT   = 5;
   localparam int unsigned AUTO_BIT = 7;
   localparam int unsigned LOCK_BIT = 6;
   localparam int unsigned ACQ_BIT  = 5;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic [2:0] {
      RS_NONE,
      RS_CTRL,
      RS_BW,
      RS_MHI,
      RS_MLO
   } reg_sel_e;
endpackage

// File: rtl/pllrb_bw_ctrl.sv
module pllrb_bw_ctrl
   import pllrb_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_bw,
   input  logic  wr_auto,
   input  logic  wr_acq,
   input  logic  core_locked,
   input  logic  core_tracking,
   output logic  auto_q,
   output logic  acq_cmd,
   output byte_t rd_byte
);
   logic acq_shadow_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         auto_q       <= 1'b0;
         acq_shadow_q <= 1'b0;
      end else if (wr_bw) begin
         auto_q <= wr_auto;
         if (!auto_q) acq_shadow_q <= wr_acq;
      end
   end

   assign acq_cmd = acq_shadow_q;

   always_comb begin
      rd_byte           = '0;
      rd_byte[AUTO_BIT] = auto_q;
      rd_byte[LOCK_BIT] = auto_q & core_locked;
      rd_byte[ACQ_BIT]  = auto_q ? core_tracking : acq_shadow_q;
   end

   // R5 / R7: the shadow cannot move while automatic mode is in force
   p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      auto_q |=> $stable(acq_shadow_q));

   // R6: a manual write lands on the command output
   p_manual_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_bw && !auto_q) |=> (acq_cmd == $past(wr_acq)));
endmodule

// File: rtl/pllrb_mult.sv
module pllrb_mult
   import pllrb_pkg::*;
#(
   parameter int unsigned MULT_W      = 12,
   parameter int unsigned MULT_RESET  = 'h040,
   parameter bit          ZERO_AS_ONE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic              locked_out,
   input  byte_t             wdata,
   output byte_t             hi_byte,
   output byte_t             lo_byte,
   output logic [MULT_W-1:0] mult_eff
);
   localparam int unsigned HI_W = MULT_W - BYTE_W;

   logic [MULT_W-1:0] mult_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mult_q <= MULT_W'(MULT_RESET);
      end else if (!locked_out) begin
         if (wr_hi) mult_q[MULT_W-1:BYTE_W] <= wdata[HI_W-1:0];
         if (wr_lo) mult_q[BYTE_W-1:0]      <= wdata;
      end
   end

   assign hi_byte = BYTE_W'(mult_q[MULT_W-1:BYTE_W]);
   assign lo_byte = mult_q[BYTE_W-1:0];

   generate
      if (ZERO_AS_ONE) begin : g_clamp
         assign mult_eff = (mult_q == '0) ? MULT_W'(1) : mult_q;

         // R10: the core never sees a zero multiplier
         p_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
            mult_eff != '0);
      end else begin : g_raw
         assign mult_eff = mult_q;
      end
   endgenerate

   // R9: no multiplier change while the PLL runs
   p_mult_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      locked_out |=> $stable(mult_q));
endmodule

// File: rtl/pll_regbank.sv
module pll_regbank
   import pllrb_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned MULT_W      = 12,
   parameter int unsigned MULT_RESET  = 'h040,
   parameter bit          ZERO_AS_ONE = 1'b1,
   parameter int unsigned CTRL_OFS    = 'h6,
   parameter int unsigned BW_OFS      = 'h7,
   parameter int unsigned MHI_OFS     = 'h8,
   parameter int unsigned MLO_OFS     = 'h9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              core_locked,
   input  logic              core_tracking,
   output logic              pll_enable,
   output logic              bw_auto,
   output logic              acq_track_cmd,
   output logic [MULT_W-1:0] mult_eff
);
   localparam int unsigned SPAN = 1 << ADDR_W;

   generate
      if (MULT_W <= BYTE_W || MULT_W > 2*BYTE_W) begin : g_bad_mult
         $error("pll_regbank: MULT_W must be 9..16");
      end
      if (CTRL_OFS >= SPAN || BW_OFS >= SPAN || MHI_OFS >= SPAN || MLO_OFS >= SPAN) begin : g_bad_ofs
         $error("pll_regbank: offset outside address space");
      end
      if (CTRL_OFS == BW_OFS || CTRL_OFS == MHI_OFS || CTRL_OFS == MLO_OFS ||
          BW_OFS == MHI_OFS || BW_OFS == MLO_OFS || MHI_OFS == MLO_OFS) begin : g_dup_ofs
         $error("pll_regbank: register offsets collide");
      end
      if (MULT_RESET >= (1 << MULT_W)) begin : g_bad_rst
         $error("pll_regbank: MULT_RESET wider than MULT_W");
      end
   endgenerate

   reg_sel_e sel;
   logic     en_q;
   byte_t    bw_rd, hi_rd, lo_rd;

   always_comb begin
      if      (bus_addr == ADDR_W'(CTRL_OFS)) sel = RS_CTRL;
      else if (bus_addr == ADDR_W'(BW_OFS))   sel = RS_BW;
      else if (bus_addr == ADDR_W'(MHI_OFS))  sel = RS_MHI;
      else if (bus_addr == ADDR_W'(MLO_OFS))  sel = RS_MLO;
      else                                    sel = RS_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                        en_q <= 1'b0;
      else if (bus_wr && sel == RS_CTRL) en_q <= bus_wdata[EN_BIT];
   end

   assign pll_enable = en_q;

   pllrb_bw_ctrl u_bw (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_bw        (bus_wr && sel == RS_BW),
      .wr_auto      (bus_wdata[AUTO_BIT]),
      .wr_acq       (bus_wdata[ACQ_BIT]),
      .core_locked  (core_locked),
      .core_tracking(core_tracking),
      .auto_q       (bw_auto),
      .acq_cmd      (acq_track_cmd),
      .rd_byte      (bw_rd)
   );

   pllrb_mult #(
      .MULT_W     (MULT_W),
      .MULT_RESET (MULT_RESET),
      .ZERO_AS_ONE(ZERO_AS_ONE)
   ) u_mult (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hi     (bus_wr && sel == RS_MHI),
      .wr_lo     (bus_wr && sel == RS_MLO),
      .locked_out(en_q),
      .wdata     (bus_wdata),
      .hi_byte   (hi_rd),
      .lo_byte   (lo_rd),
      .mult_eff  (mult_eff)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (sel)
         RS_CTRL: bus_rdata[EN_BIT] = en_q;
         RS_BW:   bus_rdata = bw_rd;
         RS_MHI:  bus_rdata = hi_rd;
         RS_MLO:  bus_rdata = lo_rd;
         default: bus_rdata = '0;
      endcase
   end

   // R2: the enable follows a control write on the next edge
   p_enable_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(CTRL_OFS)) |=> (pll_enable == $past(bus_wdata[EN_BIT])));

   // R3: lock reads 0 in manual mode
   p_lock_manual_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(BW_OFS) && !bw_auto) |-> !bus_rdata[LOCK_BIT]);

   // R3: lock reads live core state in automatic mode
   p_lock_auto_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(BW_OFS) && bw_auto) |-> (bus_rdata[LOCK_BIT] == core_locked));

   // R8: upper nibble of the high multiplier byte is always 0
   p_hi_nibble_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(MHI_OFS)) |-> (bus_rdata[7:4] == 4'h0));
endmodule

// File: tb/pll_regbank_tb.sv
`timescale 1ns/1ps
module pll_regbank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        core_locked = 1'b0;
   logic        core_tracking = 1'b0;
   logic        pll_enable, bw_auto, acq_track_cmd;
   logic [11:0] mult_eff;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pll_regbank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_locked(core_locked),
      .core_tracking(core_tracking), .pll_enable(pll_enable), .bw_auto(bw_auto),
      .acq_track_cmd(acq_track_cmd), .mult_eff(mult_eff)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1 chk(tag, {8'h0, bus_rdata}, {8'h0, exp});
   endtask

   task automatic t_reset;
      core_locked = 1'b1; core_tracking = 1'b1;
      rd_chk("R1 ctrl", 4'h6, 8'h00);
      rd_chk("R1 bw", 4'h7, 8'h00);
      rd_chk("R1 mhi", 4'h8, 8'h00);
      rd_chk("R1 mlo", 4'h9, 8'h40);
      chk("R1 mult_eff", {4'h0, mult_eff}, 16'h040);
      chk("R1 pll_enable", {15'h0, pll_enable}, 16'h0);
      core_locked = 1'b0; core_tracking = 1'b0;
   endtask

   task automatic t_ctrl;
      @(negedge clk);
      bus_addr = 4'h6; bus_wdata = 8'hFF; bus_wr = 1'b1;
      #1 chk("R12 old value during strobe", {8'h0, bus_rdata}, 16'h00);
      @(negedge clk);
      bus_wr = 1'b0;
      #1 chk("R12/R2 ctrl after edge", {8'h0, bus_rdata}, 16'h20);
      chk("R2 pll_enable set", {15'h0, pll_enable}, 16'h1);
      wr(4'h6, 8'hDF);
      rd_chk("R2 ctrl cleared", 4'h6, 8'h00);
      chk("R2 pll_enable clear", {15'h0, pll_enable}, 16'h0);
   endtask

   task automatic t_mult_layout;
      wr(4'h8, 8'hFA);
      wr(4'h9, 8'h5C);
      rd_chk("R8 mhi nibble", 4'h8, 8'h0A);
      rd_chk("R8 mlo", 4'h9, 8'h5C);
      chk("R8 mult_eff", {4'h0, mult_eff}, 16'hA5C);
   endtask

   task automatic t_mult_block;
      wr(4'h6, 8'h20);
      wr(4'h8, 8'h03);
      wr(4'h9, 8'h11);
      rd_chk("R9 mhi held", 4'h8, 8'h0A);
      rd_chk("R9 mlo held", 4'h9, 8'h5C);
      chk("R9 mult_eff held", {4'h0, mult_eff}, 16'hA5C);
      wr(4'h6, 8'h00);
      wr(4'h8, 8'h03);
      wr(4'h9, 8'h11);
      chk("R9 mult_eff after unlock", {4'h0, mult_eff}, 16'h311);
   endtask

   task automatic t_zero;
      wr(4'h8, 8'h00);
      wr(4'h9, 8'h00);
      rd_chk("R10 mlo reads zero", 4'h9, 8'h00);
      chk("R10 zero clamped", {4'h0, mult_eff}, 16'h001);
      wr(4'h9, 8'h01);
      chk("R10 one", {4'h0, mult_eff}, 16'h001);
      wr(4'h9, 8'h02);
      chk("R10 two", {4'h0, mult_eff}, 16'h002);
   endtask

   task automatic t_lock;
      core_locked = 1'b1;
      rd_chk("R3 manual lock zero", 4'h7, 8'h00);
      wr(4'h7, 8'h40);
      rd_chk("R4 manual lock write ignored", 4'h7, 8'h00);
      wr(4'h7, 8'h80);
      rd_chk("R3 auto locked", 4'h7, 8'hC0);
      core_locked = 1'b0;
      rd_chk("R3 auto unlocked", 4'h7, 8'h80);
      wr(4'h7, 8'hC0);
      rd_chk("R4 auto lock write ignored", 4'h7, 8'h80);
      wr(4'h7, 8'h00);
   endtask

   task automatic t_acq;
      wr(4'h7, 8'h20);
      rd_chk("R6 manual acq set", 4'h7, 8'h20);
      chk("R6 cmd high", {15'h0, acq_track_cmd}, 16'h1);
      wr(4'h7, 8'h00);
      rd_chk("R6 manual acq clear", 4'h7, 8'h00);
      chk("R6 cmd low", {15'h0, acq_track_cmd}, 16'h0);
      wr(4'h7, 8'hA0);
      core_tracking = 1'b0;
      rd_chk("R5 auto acq shows core", 4'h7, 8'h80);
      wr(4'h7, 8'h80);
      core_tracking = 1'b1;
      rd_chk("R5 auto tracking shows core", 4'h7, 8'hA0);
      chk("R5 shadow kept", {15'h0, acq_track_cmd}, 16'h1);
      core_tracking = 1'b0;
      wr(4'h7, 8'h00);
      rd_chk("R7 shadow restored", 4'h7, 8'h20);
      chk("R7 cmd restored", {15'h0, acq_track_cmd}, 16'h1);
   endtask

   task automatic t_unmapped;
      wr(4'h0, 8'hFF);
      wr(4'hF, 8'hFF);
      rd_chk("R11 offset 0", 4'h0, 8'h00);
      rd_chk("R11 offset 5", 4'h5, 8'h00);
      rd_chk("R11 offset A", 4'hA, 8'h00);
      rd_chk("R11 offset F", 4'hF, 8'h00);
      rd_chk("R11 ctrl untouched", 4'h6, 8'h00);
      rd_chk("R11 mlo untouched", 4'h9, 8'h02);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ctrl();
      t_mult_layout();
      t_mult_block();
      t_zero();
      t_lock();
      t_acq();
      t_unmapped();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule